// File: doc/BRIEF.md
# Reloadable Broadcast Timer Channel

A single down-counting timer channel, meant to serve as a wake-up source that keeps running while processor-local timers are powered off. Software places a 64-bit reload value in two 32-bit words. It then arms the channel through a control word that holds the run enable, the mode and the interrupt unmask. Registers are reached over a simple single-clock register bus. A write takes effect on the clock edge where `bus_sel` and `bus_we` are both high. Reads return data combinationally from `bus_addr`.

The channel has two modes. In periodic mode the counter restarts from the reload value after each expiry, so a reload value of N-1 gives one expiry every N clocks. In single-shot mode the channel expires once, then holds at zero until software re-arms it. Each expiry sets a pending flag, whether or not the interrupt is masked. Software clears the flag by writing 1 to it. The interrupt line is the pending flag gated by the unmask bit.

The expected programming sequence is: clear the enable, write the reload words, then set the enable together with the mode. The bus and the counter share one clock.

Top module: `bcast_timer`

## Requirements
- R1: After reset, all registers read zero and `irq` is low.
- R2: The register map is as follows:
  - Offset 0x00 holds the reload low word and offset 0x04 holds the reload high word. Both are read/write over all 32 bits.
  - Offset 0x10 is the control word. Its bit 0 is the enable, bit 1 selects single-shot mode (0 selects periodic), and bit 2 is the unmask. Its upper bits read zero.
  - Offset 0x18 is the pending flag, at bit 0.
  - Any other offset reads zero, and writes to it change nothing.
- R3: Only a 0-to-1 change of the enable copies the 64-bit reload value into the counter. With a reload value of N-1, the first expiry happens N clocks after the enabling write edge. A control write that leaves the enable at 1 does not restart the count.
- R4: In periodic mode, after an expiry the counter restarts from the reload value, which gives one expiry every N clocks for a reload value of N-1.
- R5: In single-shot mode the channel expires once and then holds at zero with no further expiry. Clearing and then setting the enable re-arms it.
- R6: Each expiry sets the pending flag regardless of the unmask bit. Writing 1 to bit 0 at offset 0x18 clears it, and writing 0 there has no effect.
- R7: `irq` is high exactly when the pending flag and the unmask bit are both set.
- R8: While the enable is 0, the counter holds and no expiry occurs.
- R9: Writing the reload words while the channel runs does not alter the count in progress. The new value is used from the next restart.
- R10: When an expiry and a clearing write fall on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt: pending flag and unmask |

## Verification
A wrong counter value shows at the ports only as an expiry on the wrong edge. The bench therefore polls the pending flag on every clock and compares the number of clocks from the enabling write to each expiry with the expected period. This exposes an off-by-one error in the load or restart path within one period.

A lost single-shot disarm, or a restart caused by a control rewrite, appears as an extra expiry inside a quiet window of a few dozen clocks.

Flag and mask faults show directly on `irq` or in the read-back of 0x18 one clock after the write or expiry that caused them.

// File: rtl/bct_pkg.sv
package bct_pkg;

  localparam logic [7:0] LOAD_BASE = 8'h00;
  localparam logic [7:0] CTRL_ADDR = 8'h10;
  localparam logic [7:0] STAT_ADDR = 8'h18;

  // bit 2: unmask, bit 1: single-shot, bit 0: enable
  typedef struct packed {
    logic ie;
    logic oneshot;
    logic en;
  } ctrl_t;

  function automatic ctrl_t ctrl_decode(input logic [2:0] bits);
    ctrl_t c;
    c.ie      = bits[2];
    c.oneshot = bits[1];
    c.en      = bits[0];
    return c;
  endfunction

  function automatic logic [2:0] ctrl_encode(input ctrl_t c);
    return {c.ie, c.oneshot, c.en};
  endfunction

  function automatic logic [7:0] word_offset(input int idx);
    return LOAD_BASE + 8'(4 * idx);
  endfunction

endpackage

// File: rtl/bct_regfile.sv
module bct_regfile
  import bct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LOAD_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              status_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LOAD_W-1:0] load_val,
  output ctrl_t             ctrl,
  output logic              start_evt,
  output logic              clr_evt
);
  localparam int HALVES = LOAD_W / DATA_W;

  logic wr;
  logic ctrl_hit;
  logic stat_hit;
  logic [HALVES-1:0] word_hit;

  assign wr       = bus_sel & bus_we;
  assign ctrl_hit = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign stat_hit = (bus_addr == ADDR_W'(STAT_ADDR));

  genvar g;
  generate
    for (g = 0; g < HALVES; g++) begin : g_word
      logic [DATA_W-1:0] q;
      assign word_hit[g] = (bus_addr == ADDR_W'(word_offset(g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                q <= '0;
        else if (wr && word_hit[g]) q <= bus_wdata;
      end
      assign load_val[g*DATA_W +: DATA_W] = q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctrl <= '0;
    else if (wr && ctrl_hit) ctrl <= ctrl_decode(bus_wdata[2:0]);
  end

  assign start_evt = wr && ctrl_hit && bus_wdata[0] && !ctrl.en;
  assign clr_evt   = wr && stat_hit && bus_wdata[0];

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < HALVES; i++) begin
      if (word_hit[i]) bus_rdata = load_val[i*DATA_W +: DATA_W];
    end
    if (ctrl_hit) bus_rdata = DATA_W'(ctrl_encode(ctrl));
    if (stat_hit) bus_rdata = DATA_W'(status_q);
  end

endmodule

// File: rtl/bct_counter.sv
module bct_counter
  import bct_pkg::*;
#(
  parameter int LOAD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              start_evt,
  output logic [LOAD_W-1:0] count,
  output logic              armed,
  output logic              expire_evt
);
  logic at_zero;
  assign at_zero    = (count == '0);
  assign expire_evt = ctrl.en && armed && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (start_evt) begin
      count <= load_val;
      armed <= 1'b1;
    end else if (expire_evt) begin
      if (ctrl.oneshot) armed <= 1'b0;
      else              count <= load_val;
    end else if (ctrl.en && armed) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/bct_status.sv
module bct_status
  import bct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  expire_evt,
  input  logic  clr_evt,
  output logic  status_q,
  output logic  irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status_q <= 1'b0;
    else if (expire_evt) status_q <= 1'b1;
    else if (clr_evt)    status_q <= 1'b0;
  end

  assign irq = status_q & ctrl.ie;

endmodule

// File: rtl/bcast_timer.sv
module bcast_timer
  import bct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LOAD_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [LOAD_W-1:0] load_val;
  logic [LOAD_W-1:0] count;
  logic              armed;
  logic              start_evt;
  logic              clr_evt;
  logic              expire_evt;
  logic              status_q;

  bct_regfile #(.DATA_W(DATA_W), .LOAD_W(LOAD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_q(status_q),
    .bus_rdata(bus_rdata), .load_val(load_val), .ctrl(ctrl),
    .start_evt(start_evt), .clr_evt(clr_evt)
  );

  bct_counter #(.LOAD_W(LOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .load_val(load_val),
    .start_evt(start_evt), .count(count), .armed(armed),
    .expire_evt(expire_evt)
  );

  bct_status u_stat (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .expire_evt(expire_evt),
    .clr_evt(clr_evt), .status_q(status_q), .irq(irq)
  );

endmodule

// File: rtl/bct_chk.sv
module bct_chk
  import bct_pkg::*;
#(
  parameter int LOAD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input ctrl_t             ctrl,
  input logic [LOAD_W-1:0] load_val,
  input logic [LOAD_W-1:0] count,
  input logic              start_evt,
  input logic              expire_evt,
  input logic              clr_evt,
  input logic              status_q,
  input logic              irq
);
  assert_start_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> count == $past(load_val));

  assert_periodic_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !ctrl.oneshot) |=> count == $past(load_val));

  assert_single_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && ctrl.oneshot) |=> (count == '0 && !expire_evt));

  assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> status_q);

  assert_flag_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q) |-> $past(clr_evt));

  assert_irq_needs_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ctrl.ie);

  assert_idle_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !start_evt) |=> $stable(count));

endmodule

bind bcast_timer bct_chk #(.LOAD_W(LOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .load_val(load_val),
  .count(count), .start_evt(start_evt), .expire_evt(expire_evt),
  .clr_evt(clr_evt), .status_q(status_q), .irq(irq)
);

// File: tb/sim_bcast_timer.sv
module sim_bcast_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_CTRL = 8'h10, A_STAT = 8'h18;

  bcast_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  // expected clocks from arming edge to first expiry for a reload value
  function automatic int period_of(input int reload);
    return reload + 1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_flag(input int limit, output int j);
    logic [31:0] s;
    j = limit + 1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      rd(A_STAT, s);
      if (s[0]) begin j = k; break; end
    end
  endtask

  task automatic idle_clean;
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_LO, d);   chk("R1 low word", d, 0);
    rd(A_HI, d);   chk("R1 high word", d, 0);
    rd(A_CTRL, d); chk("R1 control", d, 0);
    rd(A_STAT, d); chk("R1 flag", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(A_LO, 32'hDEADBEEF);
    wr(A_HI, 32'h12345678);
    wr(A_CTRL, 32'hFFFF_FFFC);
    wr(8'h08, 32'hAAAA5555);
    rd(A_LO, d);   chk("R2 low word", d, 32'hDEADBEEF);
    rd(A_HI, d);   chk("R2 high word", d, 32'h12345678);
    rd(A_CTRL, d); chk("R2 control upper bits", d, 32'h4);
    rd(8'h08, d);  chk("R2 unmapped read", d, 0);
    wr(A_CTRL, 32'h0);
    wr(A_HI, 32'h0);
  endtask

  task automatic t_first;
    int j;
    wr(A_LO, 9);
    wr(A_CTRL, 32'h1);
    wait_flag(50, j);
    chk("R3 first expiry delay", j, period_of(9));
    idle_clean();
  endtask

  task automatic t_period;
    int j;
    wr(A_LO, 4);
    wr(A_CTRL, 32'h5);
    wait_flag(50, j);
    chk("R4 first period", j, period_of(4));
    wr(A_STAT, 1);
    wait_flag(50, j);
    chk("R4 second period", j, period_of(4) - 1);
    wr(A_STAT, 1);
    wait_flag(50, j);
    chk("R4 third period", j, period_of(4) - 1);
    idle_clean();
  endtask

  task automatic t_same_edge;
    logic [31:0] d;
    int j;
    wr(A_LO, 0);
    wr(A_CTRL, 32'h1);
    wait_flag(10, j);
    chk("R4 zero reload expiry", j, 1);
    wr(A_STAT, 1);
    rd(A_STAT, d);
    chk("R10 set wins over clear", d, 1);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 1);
    rd(A_STAT, d);
    chk("R6 clear by writing 1", d, 0);
  endtask

  task automatic t_single;
    int j;
    wr(A_LO, 5);
    wr(A_CTRL, 32'h3);
    wait_flag(50, j);
    chk("R5 single expiry delay", j, period_of(5));
    wr(A_STAT, 1);
    wait_flag(40, j);
    chk("R5 no second expiry", j, 41);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h3);
    wait_flag(50, j);
    chk("R5 re-arm delay", j, period_of(5));
    idle_clean();
  endtask

  task automatic t_mask;
    logic [31:0] d;
    int j;
    wr(A_LO, 2);
    wr(A_CTRL, 32'h3);
    wait_flag(20, j);
    chk("R6 flag sets while masked", j, period_of(2));
    chk("R7 irq low while masked", irq, 0);
    wr(A_STAT, 0);
    rd(A_STAT, d);
    chk("R6 writing 0 keeps flag", d, 1);
    wr(A_CTRL, 32'h7);
    chk("R7 irq high when unmasked", irq, 1);
    wr(A_STAT, 1);
    chk("R7 irq low after clear", irq, 0);
    wait_flag(20, j);
    chk("R3 rewrite with enable held does not restart", j, 21);
    idle_clean();
  endtask

  task automatic t_disable;
    int j;
    wr(A_LO, 9);
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 32'h0);
    wait_flag(30, j);
    chk("R8 no expiry while disabled", j, 31);
    idle_clean();
  endtask

  task automatic t_reload;
    int j;
    wr(A_LO, 9);
    wr(A_CTRL, 32'h1);
    wr(A_LO, 4);
    wait_flag(50, j);
    chk("R9 running count unaffected", j, period_of(9) - 1);
    wr(A_STAT, 1);
    wait_flag(50, j);
    chk("R9 new value at restart", j, period_of(4) - 1);
    idle_clean();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_first();
    t_period();
    t_same_edge();
    t_single();
    t_mask();
    t_disable();
    t_reload();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule